// File: doc/BRIEF.md
# Horizontal Microcode Sequencer

This block is the control unit of a microprogrammed processor. It keeps two on-chip tables indexed by a microprogram row: a control table of 32-bit horizontal control words and a successor table of 16-bit entries. Each entry holds two 8-bit candidate rows. The current row is held in a register. Every field of the control word at that row goes straight out to the datapath as a control line. These lines are the ALU operation, the operand-2, address, PC and register-source selects, the data-bus select, six load/write strobes, the condition select and the index enable.

On every clock the sequencer chooses the next row. A 4-way multiplexer, steered by the condition field, tests one ALU flag. That result picks one of the two candidate rows. When the index enable is set, the 7-bit opcode is added to the chosen candidate, so one row can dispatch to a per-opcode jump table. Row 0 is the start of instruction fetch, and every instruction sequence returns there.

Both tables are filled through synchronous write ports. The block comes out of reset at row 0.

Top module: `ucode_sequencer`

## Requirements
- R1: Each table has 256 rows with a synchronous write port (enable, address, data) that updates the row on the rising edge. The control outputs always show the control-table row at `upc_o`.
- R2: Control word layout: aluop [3:0], op2sel [5:4], addrsel [7:6], pcsel [9:8], regsrc [11:10], datasel [13:12], cond [15:14], indexsel [16], pcload [17], dwrite [18], swrite [19], irload [20], imload [21], datawrite [22]. Bits [31:23] drive nothing.
- R3: In a successor entry, bits [15:8] are the row taken when the tested condition is true and bits [7:0] the row taken when it is false.
- R4: The condition field value 0 tests the z flag, 1 tests n, 2 tests c, and 3 is always true. The next row is the true or the false candidate accordingly.
- R5: When both candidates are equal, the next row is that value whatever the flags are.
- R6: With indexsel = 1, the next row is the chosen candidate plus the zero-extended opcode, modulo 256 (candidate 2, opcode 10 gives row 12; candidate 0xF0, opcode 0x7F gives row 0x6F).
- R7: With indexsel = 0, the opcode has no effect on the next row.
- R8: Driving `rst_n` low forces `upc_o` to 0 at once. After `rst_n` rises, the row stays 0 through two rising edges and first advances on the third.
- R9: A write to the successor entry of the row being executed, at the same edge that leaves that row, does not change that transition. The new content governs the next visit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 7 | Opcode of the current instruction |
| flag_n_i | input | 1 | ALU negative flag |
| flag_z_i | input | 1 | ALU zero flag |
| flag_c_i | input | 1 | ALU carry flag |
| cs_we_i | input | 1 | Control table write enable |
| cs_addr_i | input | 8 | Control table write row |
| cs_wdata_i | input | 32 | Control table write word |
| ds_we_i | input | 1 | Successor table write enable |
| ds_addr_i | input | 8 | Successor table write row |
| ds_wdata_i | input | 16 | Successor table write entry |
| upc_o | output | 8 | Current microprogram row |
| aluop_o | output | 4 | ALU operation |
| op2sel_o | output | 2 | ALU operand-2 select |
| addrsel_o | output | 2 | Address bus select |
| pcsel_o | output | 2 | PC source select |
| regsrc_o | output | 2 | Register write source select |
| datasel_o | output | 2 | Data bus source select |
| cond_o | output | 2 | Condition select of the current row |
| indexsel_o | output | 1 | Opcode index enable of the current row |
| pcload_o | output | 1 | PC load strobe |
| dwrite_o | output | 1 | Destination register write strobe |
| swrite_o | output | 1 | Source register write strobe |
| irload_o | output | 1 | Instruction register load strobe |
| imload_o | output | 1 | Immediate register load strobe |
| datawrite_o | output | 1 | Memory write strobe |

## Verification
Two things can happen at the same edge: a table write and a row transition that reads the very entry being written. The bench provokes this by rewriting the successor entry of the current row in the cycle that leaves it. The transition must follow the old entry, and the next return to that row must follow the new one. A second collision comes from rewriting the control word of a dispatch row while the sequence is elsewhere. This is done between sweeps over all 32 condition/flag combinations and all 128 opcodes. Each step is judged against an arithmetic model of the two tables kept in the bench.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;

  // Number of control word bits that drive control lines.
  localparam int unsigned CTL_USED = 23;

  typedef enum logic [1:0] {
    TEST_Z      = 2'd0,
    TEST_N      = 2'd1,
    TEST_C      = 2'd2,
    TEST_ALWAYS = 2'd3
  } test_sel_e;

  // Packed from MSB to LSB: the bit positions are part of the
  // microcode format that the tables are written in.
  typedef struct packed {
    logic       datawrite;  // 22
    logic       imload;     // 21
    logic       irload;     // 20
    logic       swrite;     // 19
    logic       dwrite;     // 18
    logic       pcload;     // 17
    logic       indexsel;   // 16
    test_sel_e  cond;       // 15:14
    logic [1:0] datasel;    // 13:12
    logic [1:0] regsrc;     // 11:10
    logic [1:0] pcsel;      // 9:8
    logic [1:0] addrsel;    // 7:6
    logic [1:0] op2sel;     // 5:4
    logic [3:0] aluop;      // 3:0
  } uctl_t;

  function automatic uctl_t split_ctl(input logic [CTL_USED-1:0] w);
    return uctl_t'(w);
  endfunction

endpackage

// File: rtl/ucseq_store.sv
// Single write port, combinational read port table.
module ucseq_store #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/ucseq_cond_sel.sv
// Flag multiplexer steered by the condition field.
module ucseq_cond_sel
  import ucseq_pkg::*;
(
  input  test_sel_e sel,
  input  logic      flag_n,
  input  logic      flag_z,
  input  logic      flag_c,
  output logic      taken
);
  always_comb begin
    unique case (sel)
      TEST_Z:      taken = flag_z;
      TEST_N:      taken = flag_n;
      TEST_C:      taken = flag_c;
      TEST_ALWAYS: taken = 1'b1;
      default:     taken = 1'b1;
    endcase
  end
endmodule

// File: rtl/ucseq_next_row.sv
// Candidate choice and optional opcode indexing.
module ucseq_next_row #(
  parameter int unsigned ROW_W = 8,
  parameter int unsigned OPC_W = 7
) (
  input  logic [2*ROW_W-1:0] succ,
  input  logic               taken,
  input  logic               index_en,
  input  logic [OPC_W-1:0]   opcode,
  output logic [ROW_W-1:0]   row_next
);
  logic [ROW_W-1:0] tgt;
  logic [ROW_W-1:0] opc_ext;
  logic [ROW_W-1:0] offset;

  assign tgt = taken ? succ[2*ROW_W-1:ROW_W] : succ[ROW_W-1:0];

  generate
    if (OPC_W < ROW_W) begin : g_widen
      assign opc_ext = {{(ROW_W-OPC_W){1'b0}}, opcode};
    end else begin : g_trunc
      assign opc_ext = opcode[ROW_W-1:0];
    end
  endgenerate

  assign offset   = index_en ? opc_ext : '0;
  // Sum is kept to ROW_W bits, so it wraps around the table.
  assign row_next = tgt + offset;

endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import ucseq_pkg::*;
#(
  parameter int unsigned ROW_W = 8,
  parameter int unsigned OPC_W = 7,
  parameter int unsigned CW_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic              flag_n_i,
  input  logic              flag_z_i,
  input  logic              flag_c_i,
  input  logic              cs_we_i,
  input  logic [ROW_W-1:0]  cs_addr_i,
  input  logic [CW_W-1:0]   cs_wdata_i,
  input  logic              ds_we_i,
  input  logic [ROW_W-1:0]  ds_addr_i,
  input  logic [2*ROW_W-1:0] ds_wdata_i,
  output logic [ROW_W-1:0]  upc_o,
  output logic [3:0]        aluop_o,
  output logic [1:0]        op2sel_o,
  output logic [1:0]        addrsel_o,
  output logic [1:0]        pcsel_o,
  output logic [1:0]        regsrc_o,
  output logic [1:0]        datasel_o,
  output logic [1:0]        cond_o,
  output logic              indexsel_o,
  output logic              pcload_o,
  output logic              dwrite_o,
  output logic              swrite_o,
  output logic              irload_o,
  output logic              imload_o,
  output logic              datawrite_o
);
  localparam int unsigned SUCC_W = 2 * ROW_W;

  // Reset: asserted asynchronously, released after two edges.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_sync_q[1];

  // Tables
  logic [ROW_W-1:0]  row_q;
  logic [ROW_W-1:0]  row_d;
  logic [CW_W-1:0]   cw;
  logic [SUCC_W-1:0] succ;

  ucseq_store #(.ADDR_W(ROW_W), .DATA_W(CW_W)) u_ctl_tab (
    .clk   (clk),
    .we    (cs_we_i),
    .waddr (cs_addr_i),
    .wdata (cs_wdata_i),
    .raddr (row_q),
    .rdata (cw)
  );

  ucseq_store #(.ADDR_W(ROW_W), .DATA_W(SUCC_W)) u_succ_tab (
    .clk   (clk),
    .we    (ds_we_i),
    .waddr (ds_addr_i),
    .wdata (ds_wdata_i),
    .raddr (row_q),
    .rdata (succ)
  );

  // Field split
  uctl_t ctl;
  logic  ctl_spare_unused;

  assign ctl              = split_ctl(cw[CTL_USED-1:0]);
  assign ctl_spare_unused = ^cw[CW_W-1:CTL_USED];

  // Sequencing
  logic             taken;
  logic [ROW_W-1:0] row_next;

  ucseq_cond_sel u_cond (
    .sel    (ctl.cond),
    .flag_n (flag_n_i),
    .flag_z (flag_z_i),
    .flag_c (flag_c_i),
    .taken  (taken)
  );

  ucseq_next_row #(.ROW_W(ROW_W), .OPC_W(OPC_W)) u_next (
    .succ     (succ),
    .taken    (taken),
    .index_en (ctl.indexsel),
    .opcode   (opcode_i),
    .row_next (row_next)
  );

  logic row_en;
  assign row_en = 1'b1;

  always_comb begin
    row_d = row_q;
    if (row_en) begin
      row_d = row_next;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      row_q <= '0;
    end else begin
      row_q <= row_d;
    end
  end

  // Outputs
  assign upc_o       = row_q;
  assign aluop_o     = ctl.aluop;
  assign op2sel_o    = ctl.op2sel;
  assign addrsel_o   = ctl.addrsel;
  assign pcsel_o     = ctl.pcsel;
  assign regsrc_o    = ctl.regsrc;
  assign datasel_o   = ctl.datasel;
  assign cond_o      = ctl.cond;
  assign indexsel_o  = ctl.indexsel;
  assign pcload_o    = ctl.pcload;
  assign dwrite_o    = ctl.dwrite;
  assign swrite_o    = ctl.swrite;
  assign irload_o    = ctl.irload;
  assign imload_o    = ctl.imload;
  assign datawrite_o = ctl.datawrite;

  // Assertions
  AST_RST_ROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_core_n) |-> (row_q == '0)); // R8

  AST_ROW_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_core_n)
    rst_core_n |=> (row_q == $past(row_next))); // R4

  AST_UNCOND_JUMP: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((succ[SUCC_W-1:ROW_W] == succ[ROW_W-1:0]) && !ctl.indexsel)
    |=> (row_q == $past(succ[ROW_W-1:0]))); // R5

  AST_ALWAYS_TRUE: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((ctl.cond == TEST_ALWAYS) && !ctl.indexsel)
    |=> (row_q == $past(succ[SUCC_W-1:ROW_W]))); // R4

  AST_INDEX_IGNORED: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!ctl.indexsel && taken) |=> (row_q == $past(succ[SUCC_W-1:ROW_W]))); // R7

endmodule

// File: tb/ucode_sequencer_tb.sv
`timescale 1ns/1ps
module ucode_sequencer_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  opc;
  logic        fn, fz, fc;
  logic        cs_we;
  logic [7:0]  cs_addr;
  logic [31:0] cs_wdata;
  logic        ds_we;
  logic [7:0]  ds_addr;
  logic [15:0] ds_wdata;
  logic [7:0]  upc;
  logic [3:0]  aluop;
  logic [1:0]  op2sel, addrsel, pcsel, regsrc, datasel, cond;
  logic        indexsel, pcload, dwrite, swrite, irload, imload, datawrite;

  always #4 clk = ~clk;

  ucode_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .opcode_i(opc),
    .flag_n_i(fn), .flag_z_i(fz), .flag_c_i(fc),
    .cs_we_i(cs_we), .cs_addr_i(cs_addr), .cs_wdata_i(cs_wdata),
    .ds_we_i(ds_we), .ds_addr_i(ds_addr), .ds_wdata_i(ds_wdata),
    .upc_o(upc), .aluop_o(aluop), .op2sel_o(op2sel), .addrsel_o(addrsel),
    .pcsel_o(pcsel), .regsrc_o(regsrc), .datasel_o(datasel), .cond_o(cond),
    .indexsel_o(indexsel), .pcload_o(pcload), .dwrite_o(dwrite),
    .swrite_o(swrite), .irload_o(irload), .imload_o(imload),
    .datawrite_o(datawrite)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] cs_m [256];
  logic [15:0] ds_m [256];
  logic [7:0]  row_exp;

  function automatic logic [31:0] mkctl(input logic [1:0] c, input logic ix,
                                        input logic [7:0] s);
    logic [31:0] w;
    w = {s, ~s, s ^ 8'h3C, s + 8'h11};
    w[15:14] = c;
    w[16] = ix;
    return w;
  endfunction

  // Next row per R3, R4, R6, R7.
  function automatic logic [7:0] model_next(input logic [7:0] r);
    logic [31:0] w;
    logic        t;
    logic [7:0]  g;
    w = cs_m[r];
    case (w[15:14])
      2'd0: t = fz;
      2'd1: t = fn;
      2'd2: t = fc;
      default: t = 1'b1;
    endcase
    g = t ? ds_m[r][15:8] : ds_m[r][7:0];
    if (w[16]) g = g + {1'b0, opc};
    return g;
  endfunction

  task automatic check_row(input string tag);
    n_chk++;
    if (upc !== row_exp) begin
      n_fail++;
      $display("FAIL %s: row actual=%0h expected=%0h", tag, upc, row_exp);
    end
  endtask

  task automatic check_fields(input string tag);
    logic [22:0] act;
    logic [22:0] exp;
    act = {datawrite, imload, irload, swrite, dwrite, pcload, indexsel, cond,
           datasel, regsrc, pcsel, addrsel, op2sel, aluop};
    exp = cs_m[row_exp][22:0];
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s/R2: fields actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    logic [7:0] e;
    e = model_next(row_exp);
    @(posedge clk);
    if (cs_we) cs_m[cs_addr] = cs_wdata;
    if (ds_we) ds_m[ds_addr] = ds_wdata;
    @(negedge clk);
    cs_we = 1'b0;
    ds_we = 1'b0;
    row_exp = e;
    check_row(tag);
    check_fields(tag);
  endtask

  task automatic put_cs(input logic [7:0] a, input logic [31:0] d);
    cs_we = 1'b1; cs_addr = a; cs_wdata = d;
  endtask

  task automatic put_ds(input logic [7:0] a, input logic [15:0] d);
    ds_we = 1'b1; ds_addr = a; ds_wdata = d;
  endtask

  task automatic goto_zero();
    for (int k = 0; k < 300 && row_exp != 8'd0; k++) tick("SEQ");
    n_chk++;
    if (row_exp != 8'd0) begin
      n_fail++;
      $display("FAIL SEQ: row actual=%0h expected=0", upc);
    end
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(posedge clk);
      @(negedge clk);
      row_exp = 8'd0;
      check_row("R8 hold");
    end
  endtask

  initial begin
    rst_n = 1'b0; opc = '0; fn = 0; fz = 0; fc = 0;
    cs_we = 0; cs_addr = '0; cs_wdata = '0;
    ds_we = 0; ds_addr = '0; ds_wdata = '0;
    row_exp = '0;

    // R1: fill both tables under reset.
    for (int r = 0; r < 256; r++) begin
      @(negedge clk);
      put_cs(8'(r), mkctl(2'(r), 1'b0, 8'(r * 7 + 1)));
      put_ds(8'(r), {8'(r + 1), 8'(r + 1)});
      @(posedge clk);
      cs_m[r] = cs_wdata;
      ds_m[r] = ds_wdata;
    end
    @(negedge clk);
    cs_we = 0; ds_we = 0;
    row_exp = 8'd0;
    check_row("R8 in reset");
    check_fields("R1");

    release_reset();

    // R1, R5: walk all rows with unconditional successors, flags varied.
    for (int r = 0; r < 256; r++) begin
      {fn, fz, fc} = 3'(r);
      opc = 7'(r * 3);
      tick("R1 R5");
    end

    // Setup for the condition sweep.
    put_ds(8'h00, 16'hE0E0); tick("SEQ");
    put_ds(8'hE0, 16'h4041); tick("SEQ");
    put_ds(8'h40, 16'h0000); tick("SEQ");
    put_ds(8'h41, 16'h0000); tick("SEQ");
    put_cs(8'h40, mkctl(2'd3, 1'b0, 8'h40)); tick("SEQ");
    put_cs(8'h41, mkctl(2'd1, 1'b0, 8'h41)); tick("SEQ");

    // R3, R4, R7: all conditions against all flag values.
    for (int c = 0; c < 4; c++) begin
      for (int f = 0; f < 8; f++) begin
        goto_zero();
        put_cs(8'hE0, mkctl(2'(c), 1'b0, 8'(c * 8 + f)));
        opc = 7'(f * 13 + c * 31);
        tick("R7");
        {fn, fz, fc} = 3'(f);
        opc = ~opc;
        tick("R3 R4");
        tick("R4 return");
      end
    end

    // Setup for index dispatch: rows 2..129 return to 0.
    for (int r = 2; r < 130; r++) begin
      put_ds(8'(r), 16'h0000);
      tick("SEQ");
    end
    goto_zero();
    put_ds(8'hE0, 16'h0202); tick("SEQ");
    put_cs(8'hE0, mkctl(2'd3, 1'b1, 8'h5E)); tick("SEQ");

    // R6: every opcode through the jump table at row 2.
    for (int o = 0; o < 128; o++) begin
      goto_zero();
      opc = 7'(o);
      tick("R6 dispatch");
      tick("R6");
    end

    // R6: wraparound.
    goto_zero();
    put_ds(8'hE0, 16'hF0F0); tick("SEQ");
    goto_zero();
    opc = 7'h7F;
    tick("R6 wrap");
    tick("R6 wrap");

    // R6 with a false condition: candidate 0xC0 plus opcode.
    goto_zero();
    put_ds(8'hE0, 16'h20C0); tick("SEQ");
    put_cs(8'hE0, mkctl(2'd0, 1'b1, 8'hA7)); tick("SEQ");
    fz = 1'b0;
    for (int o = 64; o < 128; o++) begin
      goto_zero();
      opc = 7'(o);
      tick("R6 false");
      tick("R6 false");
    end

    // R9: rewrite the successor entry of the row being left.
    goto_zero();
    opc = 7'h50; {fn, fz, fc} = 3'b000;
    put_ds(8'h00, 16'h0505);
    tick("R9 old entry");
    goto_zero();
    tick("R9 new entry");

    // R8: asynchronous reset mid-run.
    tick("SEQ");
    tick("SEQ");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    row_exp = 8'd0;
    check_row("R8 async");
    check_fields("R8 async");
    release_reset();
    tick("R8 first step");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    done = 1'b1;
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule